// File: doc/BRIEF.md
# FIFO-fed I2C master with wait control

This block is a single-master I2C controller. The host queues bytes in a small transmit FIFO. The first byte it queues is the slave address, with the read/write direction in bit 0. On a rising edge of the master-select input `go`, the block issues START and shifts that byte out MSB first. For a write it then sends the queued data bytes, sampling the slave's acknowledge after each one. For a read it clocks in a preset number of bytes from the slave into a receive FIFO, and the host drains them through a pop strobe.

The bus is paused by holding SCL low. There are three causes of a pause. The first is running out of transmit data, which raises the transmit-idle flag `tbi`. The second is a NACK, which raises the interrupt flag `irq`. The third is a wait point chosen by the host, which also raises `irq`. A wait-select input picks between two wait points: a pause after every acknowledged byte, or a pause only when the data run out. With the FIFO feature switched off, the block always pauses after the address byte, so the host can act before data flow. Pulsing `irq_clr` releases an interrupt wait. Pushing a byte releases a data-starved wait. Dropping `go` in any wait sends STOP and returns the block to idle.

SCL timing comes from a programmable divider of the system clock. Each bit lasts four quarter periods of `clk_div+1` cycles each. SDA only moves while SCL is low, except when forming START and STOP.

Top module: `ifm_master`

## Requirements
- R1: After reset, `scl_out` and `sda_out` are 1 (released), `irq`, `tbi`, `nack` and `busy` are 0, and `rx_empty` is 1.
- R2: A transfer begins with START followed by the first transmit-FIFO byte, sent MSB first. Bit 0 of that byte selects the direction (0 write, 1 read), and the slave's acknowledge is sampled on the ninth clock.
- R3: In a write, the remaining FIFO bytes are sent in push order while every byte is acknowledged (SDA low on the ninth clock).
- R4: With `wsel`=0, an acknowledged byte that leaves the transmit FIFO empty sets `tbi` and holds SCL low. A later push clears `tbi` and sends the new byte.
- R5: A NACK (SDA high on the ninth clock) on a transmitted byte sets `irq` and `nack` right after that clock and holds SCL low with no further byte sent. Pulsing `irq_clr` resumes with the next queued byte.
- R6: With `wsel`=1, `irq` is set and SCL held low after every acknowledged byte, the address included.
- R7: With `fifo_on`=0, `irq` is set after the address byte and no data byte is sent until `irq_clr` is pulsed.
- R8: A read takes `rd_len` bytes, sampled at the start, into the receive FIFO in order. The master sends ACK after each byte except the last, sends NACK on the last, then STOP, and `busy` falls without host action.
- R9: Driving `go` low during any wait produces STOP (SDA rising while SCL is high) and returns the block to idle with both lines released.
- R10: Each SCL high period lasts exactly 2*(`clk_div`+1) clock cycles.
- R11: While SCL stays high, SDA changes only as part of START or STOP.
- R12: A transfer starts only on a rising edge of `go` with the transmit FIFO non-empty. Holding `go` high, or pushing data after the edge, starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_div | input | DIV_W | Quarter SCL period minus one, in clock cycles |
| fifo_on | input | 1 | 1: FIFO streaming; 0: pause after the address byte |
| wsel | input | 1 | 1: pause after every byte; 0: pause only when data run out |
| go | input | 1 | Master select; rising edge starts, low in a wait stops |
| irq_clr | input | 1 | Pulse to clear the interrupt flag and release the wait |
| rd_len | input | RCW | Number of bytes to read, sampled at start |
| tx_push | input | 1 | Push `tx_data` into the transmit FIFO |
| tx_data | input | 8 | Byte to queue |
| tx_full | output | 1 | Transmit FIFO full |
| rx_pop | input | 1 | Pop the head of the receive FIFO |
| rx_data | output | 8 | Head of the receive FIFO |
| rx_empty | output | 1 | Receive FIFO empty |
| scl_out | output | 1 | SCL drive, 0 pulls low, 1 releases |
| sda_out | output | 1 | SDA drive, 0 pulls low, 1 releases |
| sda_in | input | 1 | Sampled SDA line level |
| irq | output | 1 | Interrupt flag (NACK or selected wait point) |
| tbi | output | 1 | Transmit-idle flag, bus waiting for data |
| nack | output | 1 | Last transmitted byte was not acknowledged |
| busy | output | 1 | A transfer is in progress |

## Verification
A bench-side slave model decodes START, STOP and the bits from the bus, acknowledges its own address, and refuses any data byte of 0xFF. The bench sweeps write lengths and read lengths of 1 to 4 bytes against arithmetically computed byte streams. Hold checks confirm that nothing new reaches the slave during a wait. A design that dropped the held clock would leak the byte after a NACK, and one that misplaced its wait point would miss the pause after the address in non-FIFO mode. A read that is off by one would ACK the final byte or NACK too early, which the slave's ACK and NACK counts expose. The SCL high time is measured for three divider settings to catch an off-by-one in the quarter-period counter. A rising `go` with an empty FIFO is applied to check that a level-triggered start is not taken.

// File: rtl/ifm_pkg.sv
package ifm_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BIT,
        ST_ACK,
        ST_WAIT,
        ST_STOP
    } state_e;

    typedef enum logic [1:0] {
        RES_TX,
        RES_RX,
        RES_STOP
    } resume_e;

    typedef struct packed {
        state_e              st;
        logic [1:0]          ph;
        logic [2:0]          bitn;
        logic [BYTE_W-1:0]   sh;
        logic                rd;
        logic                adr;
        resume_e             res;
        logic                irq;
        logic                tbi;
        logic                nack;
        logic                ackb;
    } core_t;

    function automatic logic last_quarter(logic [1:0] ph);
        return ph == 2'd3;
    endfunction

endpackage

// File: rtl/ifm_fifo.sv
module ifm_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/ifm_tick.sv
module ifm_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt >= div);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + DIV_W'(1);
    end
endmodule

// File: rtl/ifm_core.sv
module ifm_core
    import ifm_pkg::*;
#(
    parameter int RCW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              go,
    input  logic              wsel,
    input  logic              fifo_on,
    input  logic              irq_clr,
    input  logic [RCW-1:0]    rd_len,
    input  logic              tx_empty,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [BYTE_W-1:0] rx_byte,
    input  logic              sda_in,
    output logic              scl_out,
    output logic              sda_out,
    output logic              irq,
    output logic              tbi,
    output logic              nack,
    output logic              busy,
    output state_e            state
);
    core_t          r, n;
    logic [RCW-1:0] rem, n_rem;
    logic           go_q;
    logic           txing, do_tx, do_rx;

    assign txing   = r.adr | ~r.rd;
    assign rx_byte = r.sh;
    assign irq     = r.irq;
    assign tbi     = r.tbi;
    assign nack    = r.nack;
    assign busy    = (r.st != ST_IDLE);
    assign state   = r.st;

    always_comb begin
        n       = r;
        n_rem   = rem;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        do_tx   = 1'b0;
        do_rx   = 1'b0;
        n.irq   = r.irq & ~irq_clr;
        case (r.st)
            ST_IDLE: begin
                n.tbi = 1'b0;
                if (go && !go_q && !tx_empty) begin
                    tx_pop = 1'b1;
                    n.sh   = tx_data;
                    n.rd   = tx_data[0];
                    n.adr  = 1'b1;
                    n.irq  = 1'b0;
                    n.nack = 1'b0;
                    n.st   = ST_START;
                    n.ph   = 2'd0;
                    n_rem  = rd_len;
                end
            end
            default: if (tick) begin
                case (r.st)
                    ST_START: begin
                        if (last_quarter(r.ph)) begin
                            n.st   = ST_BIT;
                            n.ph   = 2'd0;
                            n.bitn = 3'd7;
                        end else n.ph = r.ph + 2'd1;
                    end
                    ST_BIT: begin
                        if (r.ph == 2'd2 && !txing) n.sh = {r.sh[BYTE_W-2:0], sda_in};
                        if (last_quarter(r.ph)) begin
                            if (txing) n.sh = {r.sh[BYTE_W-2:0], 1'b0};
                            n.ph = 2'd0;
                            if (r.bitn == 3'd0) n.st = ST_ACK;
                            else                n.bitn = r.bitn - 3'd1;
                        end else n.ph = r.ph + 2'd1;
                    end
                    ST_ACK: begin
                        if (r.ph == 2'd2 && txing) n.ackb = sda_in;
                        if (last_quarter(r.ph)) begin
                            n.ph = 2'd0;
                            if (txing) begin
                                n.nack = r.ackb;
                                n.adr  = 1'b0;
                                if (r.adr && r.rd) begin
                                    if (r.ackb) begin
                                        n.irq = 1'b1; n.st = ST_WAIT; n.res = RES_STOP;
                                    end else if (!fifo_on || wsel) begin
                                        n.irq = 1'b1; n.st = ST_WAIT; n.res = RES_RX;
                                    end else do_rx = 1'b1;
                                end else if (r.ackb || wsel || (r.adr && !fifo_on)) begin
                                    n.irq = 1'b1; n.st = ST_WAIT; n.res = RES_TX;
                                end else do_tx = 1'b1;
                            end else begin
                                rx_push = 1'b1;
                                n_rem   = rem - RCW'(1);
                                if (rem <= RCW'(1)) n.st = ST_STOP;
                                else if (wsel) begin
                                    n.irq = 1'b1; n.st = ST_WAIT; n.res = RES_RX;
                                end else do_rx = 1'b1;
                            end
                        end else n.ph = r.ph + 2'd1;
                    end
                    ST_WAIT: begin
                        n.ph = 2'd0;
                        if (!go) begin
                            n.st  = ST_STOP;
                            n.tbi = 1'b0;
                        end else if (!r.irq) begin
                            case (r.res)
                                RES_TX:  do_tx = 1'b1;
                                RES_RX:  do_rx = 1'b1;
                                default: n.st  = ST_STOP;
                            endcase
                        end
                    end
                    ST_STOP: begin
                        if (last_quarter(r.ph)) begin
                            n.st = ST_IDLE;
                            n.ph = 2'd0;
                        end else n.ph = r.ph + 2'd1;
                    end
                    default: n.st = ST_IDLE;
                endcase
            end
        endcase
        if (do_tx) begin
            if (!tx_empty) begin
                tx_pop = 1'b1;
                n.sh   = tx_data;
                n.tbi  = 1'b0;
                n.st   = ST_BIT;
                n.ph   = 2'd0;
                n.bitn = 3'd7;
            end else begin
                n.tbi = 1'b1;
                n.st  = ST_WAIT;
                n.res = RES_TX;
            end
        end
        if (do_rx) begin
            if (n_rem == '0) n.st = ST_STOP;
            else begin
                n.st   = ST_BIT;
                n.ph   = 2'd0;
                n.bitn = 3'd7;
            end
        end
    end

    always_comb begin
        case (r.st)
            ST_START: begin scl_out = (r.ph != 2'd3); sda_out = (r.ph == 2'd0); end
            ST_BIT:   begin scl_out = r.ph[1]; sda_out = txing ? r.sh[BYTE_W-1] : 1'b1; end
            ST_ACK:   begin scl_out = r.ph[1]; sda_out = txing ? 1'b1 : (rem == RCW'(1)); end
            ST_WAIT:  begin scl_out = 1'b0; sda_out = 1'b1; end
            ST_STOP:  begin scl_out = (r.ph != 2'd0); sda_out = (r.ph == 2'd3); end
            default:  begin scl_out = 1'b1; sda_out = 1'b1; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r      <= '{st: ST_IDLE, res: RES_TX, default: '0};
            rem    <= '0;
            go_q   <= 1'b0;
        end else begin
            r      <= n;
            rem    <= n_rem;
            go_q   <= go;
        end
    end
endmodule

// File: rtl/ifm_master.sv
module ifm_master
    import ifm_pkg::*;
#(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8,
    parameter int DIV_W    = 8,
    parameter int RCW      = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              fifo_on,
    input  logic              wsel,
    input  logic              go,
    input  logic              irq_clr,
    input  logic [RCW-1:0]    rd_len,
    input  logic              tx_push,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              tx_full,
    input  logic              rx_pop,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_empty,
    output logic              scl_out,
    output logic              sda_out,
    input  logic              sda_in,
    output logic              irq,
    output logic              tbi,
    output logic              nack,
    output logic              busy
);
    logic              tick;
    logic              tx_empty, tx_pop, rx_push, rx_full_unused;
    logic [BYTE_W-1:0] tx_head, rx_byte;
    state_e            core_state;

    ifm_fifo #(.W(BYTE_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .push(tx_push), .wdata(tx_data), .pop(tx_pop),
        .rdata(tx_head), .full(tx_full), .empty(tx_empty)
    );

    ifm_fifo #(.W(BYTE_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .push(rx_push), .wdata(rx_byte), .pop(rx_pop),
        .rdata(rx_data), .full(rx_full_unused), .empty(rx_empty)
    );

    ifm_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst(rst), .div(clk_div), .tick(tick)
    );

    ifm_core #(.RCW(RCW)) u_core (
        .clk(clk), .rst(rst), .tick(tick), .go(go), .wsel(wsel),
        .fifo_on(fifo_on), .irq_clr(irq_clr), .rd_len(rd_len),
        .tx_empty(tx_empty), .tx_data(tx_head), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_byte(rx_byte), .sda_in(sda_in),
        .scl_out(scl_out), .sda_out(sda_out), .irq(irq), .tbi(tbi),
        .nack(nack), .busy(busy), .state(core_state)
    );
endmodule

// File: rtl/ifm_checker.sv
module ifm_checker
    import ifm_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   go,
    input logic   scl,
    input logic   sda,
    input logic   irq,
    input logic   tbi,
    input logic   busy,
    input state_e st
);
    // R11: with SCL high across two cycles, an SDA edge belongs to START or STOP
    p_sda_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (scl && $past(scl) && (sda != $past(sda))) |-> (st == ST_START || st == ST_STOP));

    // R4: the transmit-idle flag always coincides with SCL held low
    p_tbi_scl_low_r4: assert property (@(posedge clk) disable iff (rst)
        tbi |-> !scl);

    // R5: the interrupt flag is raised only with SCL held low
    p_irq_scl_low_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> !scl);

    // R12: a transfer only starts after master select was high
    p_start_go_r12: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(go));
endmodule

bind ifm_master ifm_checker u_chk (
    .clk(clk), .rst(rst), .go(go), .scl(scl_out), .sda(sda_out),
    .irq(irq), .tbi(tbi), .busy(busy), .st(core_state)
);

// File: tb/ifm_master_tb.sv
module ifm_master_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] clk_div = 8'd1;
    logic       fifo_on = 1'b1, wsel = 1'b0, go = 1'b0, irq_clr = 1'b0;
    logic [3:0] rd_len = 4'd0;
    logic       tx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] tx_data = 8'd0;
    logic       tx_full, rx_empty, scl_out, sda_out, sda_in, irq, tbi, nack, busy;
    logic [7:0] rx_data;
    logic       s_drv = 1'b1;

    always #5 clk = ~clk;

    assign sda_in = sda_out & s_drv;

    ifm_master u_dut (
        .clk(clk), .rst(rst), .clk_div(clk_div), .fifo_on(fifo_on), .wsel(wsel),
        .go(go), .irq_clr(irq_clr), .rd_len(rd_len), .tx_push(tx_push),
        .tx_data(tx_data), .tx_full(tx_full), .rx_pop(rx_pop), .rx_data(rx_data),
        .rx_empty(rx_empty), .scl_out(scl_out), .sda_out(sda_out), .sda_in(sda_in),
        .irq(irq), .tbi(tbi), .nack(nack), .busy(busy)
    );

    // ---------------- slave model (address 0x2A, refuses data 0xFF) ----------------
    localparam logic [6:0] SLV = 7'h2A;
    int         bitn = -1, wr_n = 0, rd_k = 0, m_ack = 0, m_nack = 0, stop_cnt = 0;
    logic [7:0] sh = 8'd0, addr_seen = 8'd0, rdbyte = 8'd0;
    logic [7:0] wr_log [16];
    logic       is_adr = 1'b0, rd_mode = 1'b0, sel = 1'b0, mn = 1'b0;
    logic       scl_p = 1'b1, sda_p = 1'b1;

    always @(posedge clk) begin
        if (scl_p && scl_out && sda_p && !sda_in) begin
            bitn = -1; is_adr = 1'b1; wr_n = 0; rd_k = 0; m_ack = 0; m_nack = 0;
            mn = 1'b0; s_drv <= 1'b1;
        end else if (scl_p && scl_out && !sda_p && sda_in) begin
            stop_cnt++; rd_mode = 1'b0; s_drv <= 1'b1;
        end else if (!scl_p && scl_out) begin
            if (bitn >= 0 && bitn < 8 && (is_adr || !rd_mode)) sh = {sh[6:0], sda_in};
            if (bitn == 8 && rd_mode && !is_adr) begin
                if (sda_in) begin m_nack++; mn = 1'b1; end
                else m_ack++;
            end
        end else if (scl_p && !scl_out) begin
            bitn++;
            if (bitn == 8) begin
                if (is_adr) begin
                    addr_seen = sh; sel = (sh[7:1] == SLV); rd_mode = sh[0];
                    s_drv <= !sel;
                end else if (!rd_mode) begin
                    wr_log[wr_n[3:0]] = sh; wr_n++;
                    s_drv <= (sh == 8'hFF);
                end else s_drv <= 1'b1;
            end else if (bitn == 9) begin
                bitn = 0; is_adr = 1'b0;
                if (rd_mode && sel && !mn) begin
                    rdbyte = 8'hA0 + 8'(rd_k); rd_k++;
                    s_drv <= rdbyte[7];
                end else s_drv <= 1'b1;
            end else if (bitn >= 1 && bitn <= 7 && rd_mode && sel && !is_adr && !mn) begin
                s_drv <= rdbyte[7 - bitn];
            end else if (bitn == 0) s_drv <= 1'b1;
        end
        scl_p = scl_out;
        sda_p = sda_in;
    end

    // ---------------- bookkeeping ----------------
    int total = 0, bad = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        tx_data = b; tx_push = 1'b1;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic clr_irq();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_tbi();
        while (!tbi) @(negedge clk);
    endtask

    task automatic wait_irq();
        while (!irq) @(negedge clk);
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_xfer(input string tag);
        int sc0;
        sc0 = stop_cnt;
        go = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        chk({tag, " stop seen"}, stop_cnt, sc0 + 1);
        chk({tag, " scl released"}, int'(scl_out), 1);
        chk({tag, " sda released"}, int'(sda_out), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle_cycles(5);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 scl", int'(scl_out), 1);
        chk("R1 sda", int'(sda_out), 1);
        chk("R1 irq", int'(irq), 0);
        chk("R1 tbi", int'(tbi), 0);
        chk("R1 nack", int'(nack), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 rx_empty", int'(rx_empty), 1);

        // R12: edge with empty FIFO, then data pushed while go held high
        go = 1'b1;
        idle_cycles(4);
        push(8'h54);
        idle_cycles(30);
        chk("R12 no start on level", int'(busy), 0);
        go = 1'b0;
        push(8'h11); push(8'h22); push(8'h33);
        idle_cycles(2);
        go = 1'b1;
        @(negedge clk);
        chk("R12 start on edge", int'(busy), 1);

        // R2 R3 R4: write drains FIFO then waits for data
        wait_tbi();
        chk("R2 address", int'(addr_seen), 8'h54);
        chk("R3 count", wr_n, 3);
        chk("R3 byte0", int'(wr_log[0]), 8'h11);
        chk("R3 byte1", int'(wr_log[1]), 8'h22);
        chk("R3 byte2", int'(wr_log[2]), 8'h33);
        chk("R4 irq quiet", int'(irq), 0);
        idle_cycles(40);
        chk("R4 held low", int'(scl_out), 0);
        chk("R4 nothing sent", wr_n, 3);
        push(8'h44);
        while (tbi) @(negedge clk);
        wait_tbi();
        chk("R4 resumed count", wr_n, 4);
        chk("R4 resumed byte", int'(wr_log[3]), 8'h44);
        finish_xfer("R9 tbi wait");

        // R3 sweep of write lengths with computed data
        for (int t = 1; t <= 4; t++) begin
            push(8'h54);
            for (int i = 0; i < t; i++) push(8'((t * 53 + i * 17 + 3) & 8'hFF));
            go = 1'b1;
            @(negedge clk);
            wait_tbi();
            chk("R3 sweep count", wr_n, t);
            for (int i = 0; i < t; i++)
                chk("R3 sweep byte", int'(wr_log[i]), (t * 53 + i * 17 + 3) & 8'hFF);
            finish_xfer("R9 sweep");
        end

        // R5: data NACK
        push(8'h54); push(8'h11); push(8'hFF); push(8'h22);
        go = 1'b1;
        @(negedge clk);
        wait_irq();
        chk("R5 nack flag", int'(nack), 1);
        chk("R5 bytes before hold", wr_n, 2);
        chk("R5 scl low", int'(scl_out), 0);
        idle_cycles(40);
        chk("R5 nothing leaks", wr_n, 2);
        clr_irq();
        wait_tbi();
        chk("R5 resumed count", wr_n, 3);
        chk("R5 resumed byte", int'(wr_log[2]), 8'h22);
        chk("R5 irq cleared", int'(irq), 0);
        finish_xfer("R9 after nack");

        // R5 R9: address NACK, stop out of irq wait
        push(8'h20);
        go = 1'b1;
        @(negedge clk);
        wait_irq();
        chk("R5 addr nack", int'(nack), 1);
        finish_xfer("R9 irq wait");
        clr_irq();

        // R6: pause after every byte
        wsel = 1'b1;
        push(8'h54); push(8'h01); push(8'h02); push(8'h03);
        go = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            wait_irq();
            chk("R6 bytes at pause", wr_n, i);
            chk("R6 scl low", int'(scl_out), 0);
            clr_irq();
        end
        wait_tbi();
        chk("R6 final count", wr_n, 3);
        finish_xfer("R9 wsel");
        wsel = 1'b0;

        // R7: FIFO off pauses after address
        fifo_on = 1'b0;
        push(8'h54); push(8'h5A);
        go = 1'b1;
        @(negedge clk);
        wait_irq();
        chk("R7 address sent", int'(addr_seen), 8'h54);
        idle_cycles(40);
        chk("R7 no data yet", wr_n, 0);
        clr_irq();
        wait_tbi();
        chk("R7 data after clear", wr_n, 1);
        chk("R7 data byte", int'(wr_log[0]), 8'h5A);
        finish_xfer("R9 fifo off");
        fifo_on = 1'b1;

        // R8: reads of 1..4 bytes
        for (int n = 1; n <= 4; n++) begin
            int sc0;
            sc0 = stop_cnt;
            rd_len = 4'(n);
            push(8'h55);
            go = 1'b1;
            idle_cycles(2);
            while (busy) @(negedge clk);
            @(negedge clk);
            chk("R8 master acks", m_ack, n - 1);
            chk("R8 master nack", m_nack, 1);
            chk("R8 stop", stop_cnt, sc0 + 1);
            for (int k = 0; k < n; k++) begin
                chk("R8 rx present", int'(rx_empty), 0);
                chk("R8 rx byte", int'(rx_data), 8'hA0 + k);
                rx_pop = 1'b1;
                @(negedge clk);
                rx_pop = 1'b0;
            end
            chk("R8 rx drained", int'(rx_empty), 1);
            go = 1'b0;
            idle_cycles(2);
        end

        // R10: SCL high time for several dividers
        for (int d = 1; d <= 3; d++) begin
            int hi;
            clk_div = 8'(d);
            rd_len = 4'd1;
            push(8'h55);
            go = 1'b1;
            @(negedge clk);
            while (scl_out) @(negedge clk);
            while (!scl_out) @(negedge clk);
            hi = 0;
            while (scl_out) begin hi++; @(negedge clk); end
            chk("R10 scl high cycles", hi, 2 * (d + 1));
            while (busy) @(negedge clk);
            chk("R10 read byte", int'(rx_data), 8'hA0);
            rx_pop = 1'b1;
            @(negedge clk);
            rx_pop = 1'b0;
            go = 1'b0;
            idle_cycles(2);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule